// File: doc/BRIEF.md
# Carrier Modulator with Idle Override

This block sits between a pulse sequencer and an output pin. While the sequencer reports that a transmission is in progress, the block either passes the baseband level straight through or overlays a locally generated square-wave carrier on it. The carrier's high time and low time are each set in clock cycles. A polarity select chooses the baseband level that receives the carrier. The other level drives the output low, which is the carrier's inactive level.

When no transmission is in progress, the output shows a programmed idle level. The pin drive enable follows a separate idle enable bit, so the pin can be released while idle. Every carrier burst starts at the beginning of a high phase, so each modulated segment begins with a full high time. The output pair is registered, so it follows the inputs with one cycle of latency.

Top module: `carrier_gate`

## Requirements
- R1: While reset is asserted, `mod_out` and `mod_oe` are both 0.
- R2: When `tx_busy` was 0 in the previous cycle, `mod_out` equals that cycle's `idle_lvl` and `mod_oe` equals that cycle's `idle_oe`.
- R3: When `tx_busy` was 1 in the previous cycle, `mod_oe` is 1.
- R4: When `tx_busy` was 1 and `car_en` was 0 in the previous cycle, `mod_out` equals that cycle's `base_lvl`.
- R5: With `car_en` = 1, the carrier is applied while `base_lvl` = 1 if `car_on_low` = 0, and while `base_lvl` = 0 if `car_on_low` = 1.
- R6: Within a carrier segment, `mod_out` repeats a pattern of `hi_cnt` cycles at 1 followed by `lo_cnt` cycles at 0.
- R7: Each carrier segment starts at the beginning of the high phase. A segment begins on the first cycle that the carrier condition holds after a cycle in which it did not hold.
- R8: A value of 0 in `hi_cnt` or `lo_cnt` gives a phase of one cycle.
- R9: While transmitting with `car_en` = 1, a baseband level that carries no carrier drives `mod_out` to 0.
- R10: The largest count, 2^CW-1, produces a phase of exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_busy | input | 1 | High while the transmitter is sending |
| base_lvl | input | 1 | Baseband pulse level |
| car_en | input | 1 | Enables carrier overlay |
| car_on_low | input | 1 | 1: carrier on low baseband level; 0: carrier on high level |
| hi_cnt | input | CW | Carrier high time in cycles (0 counts as 1) |
| lo_cnt | input | CW | Carrier low time in cycles (0 counts as 1) |
| idle_lvl | input | 1 | Output level while idle |
| idle_oe | input | 1 | Pin drive enable while idle |
| mod_out | output | 1 | Modulated output level |
| mod_oe | output | 1 | Output drive enable |

## Verification
The bench builds the block with CW = 8, so the largest count is 255. A full period at that count fits into a few hundred cycles, and the bench checks the top-of-range phase length cycle by cycle together with the zero-count clamp. Short counts such as 3 and 2 bring several carrier periods, polarity changes and burst restarts into a short run. A reference model in the bench predicts every output cycle.

// File: rtl/carrier_gate_pkg.sv
package carrier_gate_pkg;

   // Carrier phase encoding: high phase drives the carrier active level.
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } car_phase_e;

   // Next-cycle pin state.
   typedef struct packed {
      logic drive;
      logic level;
   } pin_s;

endpackage

// File: rtl/carrier_seg_detect.sv
module carrier_seg_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_busy,
   input  logic car_en,
   input  logic car_on_low,
   input  logic base_lvl,
   output logic seg_on,
   output logic seg_start
);

   logic seg_q;

   // Carrier is wanted on the baseband level opposite to car_on_low.
   assign seg_on    = tx_busy & car_en & (base_lvl ^ car_on_low);
   assign seg_start = seg_on & ~seg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q <= 1'b0;
      else        seg_q <= seg_on;
   end

endmodule

// File: rtl/carrier_osc.sv
module carrier_osc
   import carrier_gate_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seg_on,
   input  logic          seg_start,
   input  logic [CW-1:0] hi_cnt,
   input  logic [CW-1:0] lo_cnt,
   output logic          car_lvl
);

   localparam logic [CW-1:0] ONE = CW'(1);

   car_phase_e    ph_q, ph_cur, ph_nxt;
   logic [CW-1:0] cnt_q, cnt_cur, cnt_nxt;
   logic [CW-1:0] eff_hi, eff_lo, len;

   // Zero counts are clamped to a single cycle so the carrier never stalls.
   assign eff_hi = (hi_cnt == '0) ? ONE : hi_cnt;
   assign eff_lo = (lo_cnt == '0) ? ONE : lo_cnt;

   always_comb begin
      ph_cur  = seg_start ? PH_HIGH : ph_q;
      cnt_cur = seg_start ? '0 : cnt_q;
      len     = (ph_cur == PH_HIGH) ? eff_hi : eff_lo;
      if (cnt_cur >= len - ONE) begin
         ph_nxt  = (ph_cur == PH_HIGH) ? PH_LOW : PH_HIGH;
         cnt_nxt = '0;
      end else begin
         ph_nxt  = ph_cur;
         cnt_nxt = cnt_cur + ONE;
      end
   end

   assign car_lvl = (ph_cur == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_HIGH;
         cnt_q <= '0;
      end else if (seg_on) begin
         ph_q  <= ph_nxt;
         cnt_q <= cnt_nxt;
      end
   end

endmodule

// File: rtl/carrier_out_stage.sv
module carrier_out_stage
   import carrier_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_busy,
   input  logic car_en,
   input  logic base_lvl,
   input  logic seg_on,
   input  logic car_lvl,
   input  logic idle_lvl,
   input  logic idle_oe,
   output logic mod_out,
   output logic mod_oe
);

   pin_s pin_nxt, pin_q;

   always_comb begin
      if (!tx_busy) begin
         pin_nxt.drive = idle_oe;
         pin_nxt.level = idle_lvl;
      end else begin
         pin_nxt.drive = 1'b1;
         if (!car_en)     pin_nxt.level = base_lvl;
         else if (seg_on) pin_nxt.level = car_lvl;
         else             pin_nxt.level = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_nxt;
   end

   assign mod_out = pin_q.level;
   assign mod_oe  = pin_q.drive;

endmodule

// File: rtl/carrier_gate.sv
module carrier_gate #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_busy,
   input  logic          base_lvl,
   input  logic          car_en,
   input  logic          car_on_low,
   input  logic [CW-1:0] hi_cnt,
   input  logic [CW-1:0] lo_cnt,
   input  logic          idle_lvl,
   input  logic          idle_oe,
   output logic          mod_out,
   output logic          mod_oe
);

   generate
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("carrier_gate: CW must lie in 2..32");
      end
   endgenerate

   logic seg_on, seg_start, car_lvl;

   carrier_seg_detect u_seg (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_busy   (tx_busy),
      .car_en    (car_en),
      .car_on_low(car_on_low),
      .base_lvl  (base_lvl),
      .seg_on    (seg_on),
      .seg_start (seg_start)
   );

   carrier_osc #(.CW(CW)) u_osc (
      .clk      (clk),
      .rst_n    (rst_n),
      .seg_on   (seg_on),
      .seg_start(seg_start),
      .hi_cnt   (hi_cnt),
      .lo_cnt   (lo_cnt),
      .car_lvl  (car_lvl)
   );

   carrier_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_busy (tx_busy),
      .car_en  (car_en),
      .base_lvl(base_lvl),
      .seg_on  (seg_on),
      .car_lvl (car_lvl),
      .idle_lvl(idle_lvl),
      .idle_oe (idle_oe),
      .mod_out (mod_out),
      .mod_oe  (mod_oe)
   );

endmodule

// File: rtl/carrier_gate_chk.sv
module carrier_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_busy,
   input logic base_lvl,
   input logic car_en,
   input logic car_on_low,
   input logic idle_lvl,
   input logic idle_oe,
   input logic mod_out,
   input logic mod_oe
);

   logic pv, edge_seen, want_car, want_q, burst_go;

   assign want_car = tx_busy & car_en & (base_lvl != car_on_low);
   assign burst_go = want_car & ~want_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv     <= 1'b0;
         want_q <= 1'b0;
      end else begin
         pv     <= 1'b1;
         want_q <= want_car;
      end
   end

   always_ff @(posedge clk) edge_seen <= 1'b1;

   always @(negedge clk) begin
      if (!rst_n && edge_seen === 1'b1) begin
         AST_RESET_QUIET: assert (mod_out == 1'b0 && mod_oe == 1'b0); // R1
      end
   end

   AST_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(!tx_busy) |-> mod_out == $past(idle_lvl) && mod_oe == $past(idle_oe)); // R2
   AST_BUSY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(tx_busy) |-> mod_oe); // R3
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(tx_busy && !car_en) |-> mod_out == $past(base_lvl)); // R4
   AST_QUIET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(tx_busy && car_en && (base_lvl == car_on_low)) |-> !mod_out); // R9
   AST_BURST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(burst_go) |-> mod_out); // R7

endmodule

bind carrier_gate carrier_gate_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_busy   (tx_busy),
   .base_lvl  (base_lvl),
   .car_en    (car_en),
   .car_on_low(car_on_low),
   .idle_lvl  (idle_lvl),
   .idle_oe   (idle_oe),
   .mod_out   (mod_out),
   .mod_oe    (mod_oe)
);

// File: tb/carrier_gate_bench.sv
`timescale 1ns/1ps
module carrier_gate_bench;

   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_busy = 1'b0, base_lvl = 1'b0, car_en = 1'b0, car_on_low = 1'b0;
   logic [CW-1:0] hi_cnt = '0, lo_cnt = '0;
   logic          idle_lvl = 1'b0, idle_oe = 1'b0;
   logic          mod_out, mod_oe;

   always #4 clk = ~clk;

   carrier_gate #(.CW(CW)) u_carrier_gate (
      .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .base_lvl(base_lvl),
      .car_en(car_en), .car_on_low(car_on_low), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
      .idle_lvl(idle_lvl), .idle_oe(idle_oe), .mod_out(mod_out), .mod_oe(mod_oe)
   );

   typedef struct {
      bit    oe;
      bit    lvl;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   // Reference model state
   int   pos = 0;
   bit   prev_seg = 0;

   task automatic check(input bit act, input bit exp_v, input string tag, input string what);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp_v, $time);
      end
   endtask

   task automatic step(input bit busy, input bit en, input bit onlow, input bit base,
                       input bit il, input bit ioe, input int hi, input int lo, input string tag);
      exp_t e;
      bit   seg;
      int   h, l;
      @(negedge clk);
      tx_busy = busy; car_en = en; car_on_low = onlow; base_lvl = base;
      idle_lvl = il; idle_oe = ioe; hi_cnt = CW'(hi); lo_cnt = CW'(lo);
      seg = busy && en && (base != onlow);
      if (!busy) begin
         e.oe = ioe; e.lvl = il; e.tag = "R2";
      end else if (!en) begin
         e.oe = 1; e.lvl = base; e.tag = "R4";
      end else if (!seg) begin
         e.oe = 1; e.lvl = 0; e.tag = "R9";
      end else begin
         if (!prev_seg) pos = 0;
         h = (hi == 0) ? 1 : hi;
         l = (lo == 0) ? 1 : lo;
         e.oe = 1; e.lvl = ((pos % (h + l)) < h); e.tag = tag;
         pos++;
      end
      prev_seg = seg;
      q.push_back(e);
   endtask

   task automatic run(input int n, input bit busy, input bit en, input bit onlow, input bit base,
                      input int hi, input int lo, input string tag);
      for (int i = 0; i < n; i++) step(busy, en, onlow, base, 0, 0, hi, lo, tag);
   endtask

   // Monitor: compare each result one register stage after its stimulus.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(mod_oe, e.oe, (e.tag == "R2") ? "R2" : "R3", "mod_oe");
            check(mod_out, e.lvl, e.tag, "mod_out");
         end
      end
   end

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired at %0t", $time);
         finish_up();
      end
   end

   initial begin
      // R1: outputs quiet in reset
      repeat (3) @(posedge clk);
      #2;
      check(mod_out, 1'b0, "R1", "mod_out in reset");
      check(mod_oe, 1'b0, "R1", "mod_oe in reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2: idle level and idle enable
      step(0, 1, 0, 1, 1, 1, 3, 2, "R2");
      step(0, 1, 0, 1, 0, 1, 3, 2, "R2");
      step(0, 1, 0, 1, 1, 0, 3, 2, "R2");
      step(0, 0, 0, 0, 0, 0, 3, 2, "R2");

      // R3 and R4: plain pass-through while transmitting
      run(3, 1, 0, 0, 1, 3, 2, "R4");
      run(2, 1, 0, 0, 0, 3, 2, "R4");
      run(2, 1, 0, 1, 1, 3, 2, "R4");

      // R5/R6: carrier on the high baseband level, 3 high / 2 low
      run(20, 1, 1, 0, 1, 3, 2, "R6");
      run(4, 1, 1, 0, 0, 3, 2, "R9");
      // R7: burst restarts in the high phase
      run(12, 1, 1, 0, 1, 3, 2, "R7");

      // R5: carrier moved to the low baseband level
      run(15, 1, 1, 1, 0, 3, 2, "R5");
      run(3, 1, 1, 1, 1, 3, 2, "R9");
      run(7, 1, 1, 1, 0, 3, 2, "R7");
      step(0, 1, 1, 0, 1, 1, 3, 2, "R2");

      // R8: zero counts act as one cycle
      run(10, 1, 1, 0, 1, 0, 0, "R8");
      step(0, 1, 0, 1, 0, 0, 0, 4, "R2");
      run(12, 1, 1, 0, 1, 0, 4, "R8");
      step(0, 1, 0, 1, 0, 0, 2, 0, "R2");
      run(9, 1, 1, 0, 1, 2, 0, "R8");

      // R10: largest count value
      step(0, 1, 0, 1, 0, 0, 255, 1, "R2");
      run(262, 1, 1, 0, 1, 255, 1, "R10");
      step(0, 1, 0, 1, 0, 0, 1, 255, "R2");
      run(262, 1, 1, 0, 1, 1, 255, "R10");

      step(0, 0, 0, 0, 1, 1, 1, 1, "R2");
      repeat (3) @(posedge clk);
      #3;
      if (q.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R6 pending results actual=%0d expected=0", q.size());
      end
      done = 1;
      finish_up();
   end

endmodule